// File: doc/BRIEF.md
# Subcarrier Lock Serial Frame Receiver

This block listens on a one-wire serial input for frames that carry a colour subcarrier frequency word. Each frame is 67 bits long and each bit lasts two clocks. The receiver keeps the low 22 bits as the frequency word and drops the rest. A fully received word waits in a shadow register until the next line-start strobe. At that strobe it becomes the active phase increment, so the subcarrier frequency changes only at line boundaries. A 32-bit phase accumulator adds the active increment, left-aligned, on every clock, and its top bits form the subcarrier phase.

A two-bit mode input enables the lock function only when it equals binary 11. In any other mode the receiver stays idle and the active increment holds a default word set by a parameter.

Top module: `sfl_frame_rx`

## Requirements
- R1: During and just after reset, `freq_word` equals the default word (22'h21F07C), `word_valid` is 0 and `phase` is 0.
- R2: On every clock the accumulator adds `freq_word` shifted left by 10 bits, modulo 2^32. `phase` is the accumulator's top 10 bits (bits 31:22).
- R3: A frame starts only when `sdi` is sampled high after at least 134 consecutive low samples while `mode` is 11. A high sample after a shorter low run starts nothing.
- R4: Each bit occupies two clocks, and the cycle in which the frame starts is the first clock of bit 0. Each bit is sampled on its second clock. Bits arrive least significant first. Bits 0 to 21 form the word, and bits 22 to 66 have no effect on it.
- R5: At a `line_start` sampled while `mode` is 11 and a completed word is pending, `freq_word` takes that word at the same clock edge, and `word_valid` is high for exactly that one cycle.
- R6: A `line_start` with no new completed word since the last transfer leaves `freq_word` unchanged and raises no `word_valid`.
- R7: While `mode` is not 11 (00, 01 or 10), `freq_word` is forced to the default word one clock later, and the receiver ignores `sdi`. No `word_valid` is raised, and a frame sent in such a mode is never applied.
- R8: Leaving mode 11 in the middle of a frame discards the partial frame. A word that completed earlier and is still pending survives a mode change and is applied at the first `line_start` after mode 11 returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdi | input | 1 | Serial frame input |
| mode | input | 2 | Lock mode control, 11 enables |
| line_start | input | 1 | One-cycle strobe at the start of each video line |
| freq_word | output | 22 | Active subcarrier phase increment |
| word_valid | output | 1 | One-cycle pulse when a new word is applied |
| phase | output | 10 | Subcarrier phase, top bits of the accumulator |

## Verification
The assertions assume that `sdi`, `mode` and `line_start` are synchronous to `clk`, and that `line_start` is a strobe rather than a level. The bench drives every input on the falling edge. It keeps each `line_start` to a single cycle and places it well clear of the clock in which a frame completes, so transfer and completion never coincide. Before every frame that should be received, the bench first holds `sdi` low for more than a frame length, so that only the deliberate short-idle case tests the start rule.

// File: rtl/sfl_frame_rx.sv
module sfl_frame_rx #(
  parameter int FRAME_BITS   = 67,
  parameter int WORD_BITS    = 22,
  parameter int CLKS_PER_BIT = 2,
  parameter int ACC_BITS     = 32,
  parameter int PHASE_BITS   = 10,
  parameter logic [WORD_BITS-1:0] DEFAULT_WORD = 22'h21F07C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sdi,
  input  logic [1:0]            mode,
  input  logic                  line_start,
  output logic [WORD_BITS-1:0]  freq_word,
  output logic                  word_valid,
  output logic [PHASE_BITS-1:0] phase
);
  localparam int IDLE_LEN = FRAME_BITS * CLKS_PER_BIT;
  localparam int IW       = $clog2(IDLE_LEN + 1);
  localparam int BW       = $clog2(FRAME_BITS);
  localparam int SW       = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int LSH      = ACC_BITS - WORD_BITS;

  logic                 en, armed, start, bit_tick, done, xfer;
  logic                 rx_busy, pending;
  logic [IW-1:0]        idle_cnt;
  logic [BW-1:0]        bit_idx;
  logic [SW-1:0]        sub_cnt;
  logic [WORD_BITS-1:0] word_sr, shadow;
  logic [ACC_BITS-1:0]  acc;

  assign en       = (mode == 2'b11);
  assign armed    = (idle_cnt == IW'(IDLE_LEN));
  assign start    = en && !rx_busy && armed && sdi;
  assign bit_tick = rx_busy && (sub_cnt == SW'(CLKS_PER_BIT - 1));
  assign done     = bit_tick && (bit_idx == BW'(FRAME_BITS - 1));
  assign xfer     = en && line_start && pending;
  assign phase    = acc[ACC_BITS-1 -: PHASE_BITS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     idle_cnt <= '0;
    else if (sdi)   idle_cnt <= '0;
    else if (!armed) idle_cnt <= idle_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0;
      bit_idx <= '0;
      sub_cnt <= '0;
      word_sr <= '0;
    end else if (!en) begin
      rx_busy <= 1'b0;
    end else if (start) begin
      rx_busy <= 1'b1;
      bit_idx <= '0;
      sub_cnt <= SW'(1);
    end else if (rx_busy) begin
      if (bit_tick) begin
        sub_cnt <= '0;
        if (bit_idx < BW'(WORD_BITS)) word_sr <= {sdi, word_sr[WORD_BITS-1:1]};
        if (done) rx_busy <= 1'b0;
        else      bit_idx <= bit_idx + 1'b1;
      end else begin
        sub_cnt <= sub_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shadow  <= '0;
      pending <= 1'b0;
    end else if (done) begin
      shadow  <= word_sr;
      pending <= 1'b1;
    end else if (xfer) begin
      pending <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      freq_word  <= DEFAULT_WORD;
      word_valid <= 1'b0;
      acc        <= '0;
    end else begin
      word_valid <= xfer;
      if (!en)       freq_word <= DEFAULT_WORD;
      else if (xfer) freq_word <= shadow;
      acc <= acc + {freq_word, {LSH{1'b0}}};
    end

  assert_valid_on_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(line_start) && $past(mode) == 2'b11);

  assert_hold_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_word) |-> word_valid || $past(mode) != 2'b11);

  assert_default_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode) != 2'b11 |-> freq_word == DEFAULT_WORD && !word_valid);

  assert_idle_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11 |=> !rx_busy);

  assert_start_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_busy) |-> $past(armed) && $past(sdi));

  assert_bit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |-> bit_idx < BW'(FRAME_BITS));
endmodule

// File: tb/test_sfl_frame_rx.sv
`timescale 1ns/1ps
module test_sfl_frame_rx;
  localparam logic [21:0] DEF = 22'h21F07C;

  logic clk = 1'b0, rst_n = 1'b0, sdi = 1'b0, line_start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [21:0] freq_word;
  logic        word_valid;
  logic [9:0]  phase;
  int tests = 0, fails = 0;
  bit finished = 0, running = 0;

  always #10 clk = ~clk;

  sfl_frame_rx i_sfl_frame_rx (.clk(clk), .rst_n(rst_n), .sdi(sdi), .mode(mode),
    .line_start(line_start), .freq_word(freq_word), .word_valid(word_valid), .phase(phase));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [21:0]     m_word = DEF, m_shadow = '0;
  bit              m_valid = 0, m_pending = 0, m_in = 0;
  longint unsigned m_acc = 0;
  int              m_low = 0, m_cyc = 0;
  bit              bits_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word = DEF; m_valid = 0; m_acc = 0; m_pending = 0; m_in = 0; m_low = 0;
      bits_q.delete();
    end else begin
      bit en;
      en = (mode == 2'b11);
      m_acc = (m_acc + longint'(m_word) * 1024) & 64'hFFFF_FFFF;
      m_valid = 0;
      if (!en) m_word = DEF;
      else if (line_start && m_pending) begin
        m_word = m_shadow; m_valid = 1; m_pending = 0;
      end
      if (!en) m_in = 0;
      else if (m_in) begin
        m_cyc++;
        if (m_cyc % 2 == 0) bits_q.push_back(sdi);
        if (bits_q.size() == 67) begin
          m_shadow = '0;
          for (int i = 0; i < 22; i++) m_shadow[i] = bits_q[i];
          m_pending = 1; m_in = 0;
        end
      end else if (m_low >= 134 && sdi) begin
        m_in = 1; m_cyc = 1; bits_q.delete();
      end
      if (sdi) m_low = 0; else if (m_low < 134) m_low++;
    end
  end

  always @(negedge clk) if (running) begin
    chk("R2 phase vs model", 64'(phase), m_acc >> 22);
    chk("R5 freq_word vs model", 64'(freq_word), 64'(m_word));
    chk("R5 word_valid vs model", 64'(word_valid), 64'(m_valid));
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic idle(int n); sdi = 1'b0; repeat (n) tick(); endtask
  task automatic send_bits(logic [21:0] w, logic [44:0] tail, int n);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 22) ? w[i] : tail[i-22];
      repeat (2) tick();
    end
    sdi = 1'b0;
  endtask
  task automatic line(output logic v, output logic [21:0] fw);
    line_start = 1'b1; tick(); line_start = 1'b0;
    v = word_valid; fw = freq_word;
  endtask

  logic v; logic [21:0] fw;

  initial begin
    repeat (3) tick();
    chk("R1 reset word", 64'(freq_word), 64'(DEF));
    chk("R1 reset valid", 64'(word_valid), 0);
    chk("R1 reset phase", 64'(phase), 0);
    rst_n = 1'b1; running = 1;
    chk("R1 word after release", 64'(freq_word), 64'(DEF));
    mode = 2'b11;

    idle(140); send_bits(22'h2A5A5B, 45'h0, 67); idle(4);
    line(v, fw);
    chk("R5 valid pulse", 64'(v), 1); chk("R5 word applied", 64'(fw), 64'h2A5A5B);
    tick(); chk("R5 pulse one cycle", 64'(word_valid), 0);
    line(v, fw);
    chk("R6 no new word valid", 64'(v), 0); chk("R6 word held", 64'(fw), 64'h2A5A5B);

    idle(140); send_bits(22'h3FFFFF, 45'h1FFF_FFFF_FFFF, 67); idle(4);
    line(v, fw); chk("R4 all-ones word", 64'(fw), 64'h3FFFFF);

    idle(140); send_bits(22'h000001, 45'h1FFF_FFFF_FFFF, 67); idle(4);
    line(v, fw); chk("R4 tail discarded", 64'(fw), 64'h000001);

    idle(50); send_bits(22'h155557, 45'h0, 67); idle(140);
    line(v, fw);
    chk("R3 short idle no frame", 64'(v), 0); chk("R3 word kept", 64'(fw), 64'h000001);

    idle(140); send_bits(22'h155557, 45'h0, 30);
    mode = 2'b00; tick();
    chk("R7 default when off", 64'(freq_word), 64'(DEF));
    mode = 2'b11; idle(140);
    line(v, fw);
    chk("R8 partial discarded", 64'(v), 0); chk("R8 default kept", 64'(fw), 64'(DEF));

    idle(140); send_bits(22'h00F0F1, 45'h0, 67); idle(4);
    mode = 2'b00; tick(); tick(); mode = 2'b11; tick();
    line(v, fw);
    chk("R8 pending survives", 64'(v), 1); chk("R8 pending word", 64'(fw), 64'h00F0F1);

    mode = 2'b01; idle(140); send_bits(22'h2C3C3D, 45'h0, 67); idle(4);
    line(v, fw);
    chk("R7 mode 01 no valid", 64'(v), 0); chk("R7 mode 01 default", 64'(fw), 64'(DEF));
    mode = 2'b10; line(v, fw); chk("R7 mode 10 no valid", 64'(v), 0);
    mode = 2'b11; tick(); line(v, fw);
    chk("R7 frame in off mode not pending", 64'(v), 0);
    chk("R7 default after re-enable", 64'(fw), 64'(DEF));
    idle(10);

    running = 0; finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule